// File: doc/BRIEF.md
# Serial Byte Shifter with Acknowledge Slot

This block is the data path of a two-wire serial bus controller. It holds one byte in a nine-stage shift chain: eight visible data stages and one acknowledge stage that software cannot see. The controller's timing logic supplies the synchronized clock and data line levels and starts each byte with a one-cycle `arm` pulse. The shifter then follows nine bus clock periods. It asks for the data line to be pulled low through `sda_drive_low`, which feeds an open-drain pad. It samples the line on every rising clock edge and raises `byte_done` once the ninth period has ended.

Bus data is sampled on every byte, including bytes the block sends itself. After a byte it sent, the register therefore holds the level the bus actually carried, which is the wired-AND of every driver. If another sender won the bus, the register already holds the correct byte. When receiving, the ninth period carries an acknowledge level chosen by `ack_en`, which is captured when the byte is armed. When sending, the level the far end drove in that period is reported on `ack_rx`.

The CPU may load the register only between bytes. A write made while a byte is in flight is dropped. `arm` must be given while the bus clock is low.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, `sda_drive_low`, `byte_done` and `busy` are 0, `data_out` is 0x00 and `ack_rx` is 0.
- R2: A `cpu_wr` made while `busy` is 0 loads `cpu_wdata` into the data register, and `data_out` shows the new value one cycle later.
- R3: When sending (`tx_mode`=1), bits go out most significant bit first. During data bit k (k=7 down to 0), `sda_drive_low` equals the inverse of bit k of the loaded byte. The output changes only in a cycle that follows a cycle in which `scl_in` was low: on the `arm` cycle or right after a falling edge of `scl_in`.
- R4: The line level is sampled into the chain on every rising edge of `scl_in`, whether sending or receiving. When a byte ends, `data_out` equals the eight data-period levels of the bus, with the first one in bit 7. After a send, that is the loaded byte ANDed with what any other driver put on the line.
- R5: When receiving (`tx_mode`=0), `sda_drive_low` is 0 through all eight data periods. During the ninth period it is 1 if `ack_en` was 1 on the `arm` cycle and 0 otherwise. Drive low means ACK.
- R6: One cycle after the ninth falling edge of `scl_in`, `byte_done` pulses high for exactly one cycle, `busy` falls and `sda_drive_low` is 0.
- R7: After a send, `ack_rx` holds the line level sampled on the ninth rising edge of `scl_in`, where 0 means ACK and 1 means NACK. After a receive, `ack_rx` keeps its earlier value.
- R8: A `cpu_wr` while `busy` is 1 has no effect on the data register or on the bits driven.
- R9: Changing `ack_en` after the `arm` cycle has no effect on the acknowledge level driven for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized bus clock level |
| sda_in | input | 1 | Synchronized bus data level |
| tx_mode | input | 1 | Direction for the byte armed next: 1 send, 0 receive |
| ack_en | input | 1 | Acknowledge choice for the next received byte: 1 ACK, 0 NACK |
| arm | input | 1 | One-cycle start of a byte, given while `scl_in` is low |
| cpu_wr | input | 1 | CPU write strobe for the data register |
| cpu_wdata | input | 8 | CPU write data |
| sda_drive_low | output | 1 | Request to pull the data line low |
| byte_done | output | 1 | One-cycle pulse after the ninth clock period |
| ack_rx | output | 1 | Acknowledge level seen after the last sent byte |
| data_out | output | 8 | Data register, valid while `busy` is 0 |
| busy | output | 1 | A byte is being shifted |

## Verification
On every cycle, the assertions check these rules. The drive request changes only after the bus clock was low. A receiver never pulls the line during data bits. The bit count stays inside the nine periods. The completion pulse lasts one cycle and always drops `busy`. A write while busy leaves the register alone unless a clock edge shifts it. Only the bench's scenarios can show the rest. It sweeps all 256 byte values in both directions, adds bytes where another driver pulls bits low, and toggles `ack_en` after the arm cycle. These scenarios show that the bits leave in the right order, that the captured byte is the bus byte, and that the acknowledge level follows the value held at arm time.

// File: rtl/i2c_shift_pkg.sv
package i2c_shift_pkg;
    localparam int unsigned DEF_DATA_W = 8;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;
endpackage

// File: rtl/i2c_scl_edge.sv
module i2c_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic scl_rise,
    output logic scl_fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d   = scl_in;
        scl_rise = scl_in & ~prev_q;
        scl_fall = ~scl_in & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/i2c_shift_core.sv
module i2c_shift_core
    import i2c_shift_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              tx_mode,
    input  logic              ack_en,
    input  logic              arm,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              sda_drive_low,
    output logic              byte_done,
    output logic              ack_rx,
    output logic [DATA_W-1:0] data_out,
    output logic              busy
);
    localparam int unsigned PERIODS = DATA_W + 1;
    localparam int unsigned CNT_W   = $clog2(PERIODS + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_ALL  = CNT_W'(PERIODS);

    typedef struct packed {
        logic [DATA_W:0]  chain;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        dir_e             dir;
        logic             ack_hold;
        logic             drive;
        logic             done;
        logic             ack_seen;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (cpu_wr) st_d.chain = {cpu_wdata, 1'b1};
            if (arm) begin
                st_d.busy     = 1'b1;
                st_d.cnt      = '0;
                st_d.dir      = dir_e'(tx_mode);
                st_d.ack_hold = ack_en;
                st_d.drive    = tx_mode & ~st_d.chain[DATA_W];
            end
        end else begin
            if (scl_rise && (st_q.cnt < LAST_ALL)) begin
                st_d.chain = {st_q.chain[DATA_W-1:0], sda_in};
                st_d.cnt   = st_q.cnt + 1'b1;
            end
            if (scl_fall) begin
                if (st_q.cnt == LAST_ALL) begin
                    st_d.done  = 1'b1;
                    st_d.busy  = 1'b0;
                    st_d.drive = 1'b0;
                    if (st_q.dir == DIR_TX) st_d.ack_seen = st_q.chain[0];
                end else if (st_q.cnt == LAST_DATA) begin
                    st_d.drive = (st_q.dir == DIR_RX) & st_q.ack_hold;
                end else if (st_q.cnt != '0) begin
                    st_d.drive = (st_q.dir == DIR_TX) & ~st_q.chain[DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain    <= '0;
            st_q.cnt      <= '0;
            st_q.busy     <= 1'b0;
            st_q.dir      <= DIR_RX;
            st_q.ack_hold <= 1'b0;
            st_q.drive    <= 1'b0;
            st_q.done     <= 1'b0;
            st_q.ack_seen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_drive_low = st_q.drive;
    assign byte_done     = st_q.done;
    assign ack_rx        = st_q.ack_seen;
    assign data_out      = st_q.chain[DATA_W:1];
    assign busy          = st_q.busy;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !$past(scl_in)); // R3
    AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.dir == DIR_RX && st_q.cnt < LAST_DATA) |-> !sda_drive_low); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (!busy && !sda_drive_low) ##1 !byte_done); // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_ALL); // R4
    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_wr && !scl_rise) |=> $stable(data_out)); // R8
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       tx_mode,
    input  logic       ack_en,
    input  logic       arm,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic       sda_drive_low,
    output logic       byte_done,
    output logic       ack_rx,
    output logic [7:0] data_out,
    output logic       busy
);
    logic scl_rise, scl_fall;

    i2c_scl_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_shift_core #(.DATA_W(8)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_in),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .sda_in        (sda_in),
        .tx_mode       (tx_mode),
        .ack_en        (ack_en),
        .arm           (arm),
        .cpu_wr        (cpu_wr),
        .cpu_wdata     (cpu_wdata),
        .sda_drive_low (sda_drive_low),
        .byte_done     (byte_done),
        .ack_rx        (ack_rx),
        .data_out      (data_out),
        .busy          (busy)
    );

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_done) |-> $past(busy)); // R6
endmodule

// File: tb/tb_i2c_byte_shifter.sv
module tb_i2c_byte_shifter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b0, ext_sda = 1'b1;
    logic tx_mode = 1'b0, ack_en = 1'b0, arm = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic sda_drive_low, byte_done, ack_rx, busy;
    logic [7:0] data_out;
    logic sda_bus;
    int checks = 0, errors = 0, done_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    assign sda_bus = ext_sda & ~sda_drive_low;

    i2c_byte_shifter dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .tx_mode(tx_mode), .ack_en(ack_en), .arm(arm), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .sda_drive_low(sda_drive_low),
        .byte_done(byte_done), .ack_rx(ack_rx), .data_out(data_out), .busy(busy)
    );

    always @(posedge clk) if (byte_done) done_cnt <= done_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_byte(input bit tx, input logic [7:0] wb, input bit ack,
                            input logic [8:0] ext, input bit poke, input bit last_ack);
        int d0;
        logic [7:0] bus_byte;
        logic exp_drive;
        bus_byte = tx ? (wb & ext[8:1]) : ext[8:1];
        @(negedge clk);
        scl = 1'b0;
        if (tx) begin
            cpu_wr = 1'b1; cpu_wdata = wb;
            @(negedge clk);
            cpu_wr = 1'b0;
        end
        tx_mode = tx; ack_en = ack; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        d0 = done_cnt;
        for (int i = 0; i < 9; i++) begin
            ext_sda = ext[8-i];
            repeat (3) @(negedge clk);
            scl = 1'b1;
            repeat (2) @(negedge clk);
            if (i < 8) exp_drive = tx ? ~wb[7-i] : 1'b0;
            else       exp_drive = tx ? 1'b0 : ack;
            if (i < 8) chk(tx ? "R3 send bit drive" : "R5 receive data quiet",
                           sda_drive_low, exp_drive);
            else       chk(tx ? "R3 send ack slot released" : "R5 R9 ack slot drive",
                           sda_drive_low, exp_drive);
            if (poke && i == 3) begin
                cpu_wr = 1'b1; cpu_wdata = ~wb; ack_en = ~ack;
                @(negedge clk);
                cpu_wr = 1'b0;
            end else begin
                @(negedge clk);
            end
            @(negedge clk);
            scl = 1'b0;
        end
        repeat (3) @(negedge clk);
        ext_sda = 1'b1;
        chk("R6 one done pulse", done_cnt - d0, 1);
        chk("R6 busy cleared", busy, 0);
        chk("R6 drive released", sda_drive_low, 0);
        chk(poke ? "R4 R8 bus byte kept" : "R4 bus byte captured", data_out, bus_byte);
        chk("R7 ack seen", ack_rx, tx ? ext[0] : last_ack);
        ack_en = ack;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual expired expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic last;
        repeat (3) @(negedge clk);
        chk("R1 drive", sda_drive_low, 0);
        chk("R1 done", byte_done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 data", data_out, 0);
        chk("R1 ack", ack_rx, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = 8'h3C;
        @(negedge clk);
        cpu_wr = 1'b0;
        chk("R2 idle write", data_out, 8'h3C);
        last = 1'b0;
        for (int v = 0; v < 256; v++) begin
            run_byte(1'b1, 8'(v), 1'b0, {8'hFF, v[0]}, v[2:0] == 3'd5, last);
            last = v[0];
            run_byte(1'b0, 8'h00, v[1], {8'(v), 1'b1}, v[3:0] == 4'd9, last);
        end
        run_byte(1'b1, 8'hFF, 1'b0, {8'hA5, 1'b0}, 1'b0, last);
        run_byte(1'b1, 8'hF0, 1'b0, {8'h3C, 1'b1}, 1'b1, 1'b0);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = 8'h81;
        @(negedge clk);
        cpu_wr = 1'b0;
        chk("R2 write after bytes", data_out, 8'h81);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule